// File: doc/BRIEF.md
# Relative branch and link unit

This unit owns the program counter of a simple 32-bit processor and works out where execution goes next. Each time the pipeline lets it advance, it does one of three things. It steps to the next sequential instruction. It jumps to a target given as a signed word offset from the current address. Or it returns by copying a saved link address back into the counter. A jump can also save the address of the following instruction in a link register, so that a later return comes back to it.

The unit does not evaluate conditions itself. The flag logic evaluates the condition and presents the result on `cond_pass`. A branch takes effect only when both `br_valid` and `cond_pass` are high. Decode supplies the branch fields: `br_valid`, `br_link` and `br_offset`. It also supplies a separate return request, `ret_req`. The asynchronous reset is released through an internal two-stage synchronizer, so the registers leave reset on a clock edge.

Top module: `branch_link_unit`

## Requirements
- R1: While reset is active, `pc_o` and `lr_o` are both 0x00000000.
- R2: On an edge where `adv_en` is 0, `pc_o` and `lr_o` keep their values, whatever the other inputs are.
- R3: On an advancing edge with no taken branch and no `ret_req`, `pc_o` becomes `pc_o + 4`, modulo 2^32.
- R4: A branch is taken when `br_valid` = 1 and `cond_pass` = 1. On an advancing edge with a taken branch, `pc_o` becomes `pc_o + (sign-extended 24-bit br_offset << 2)`, modulo 2^32.
- R5: The reach of a branch is +0x01FFFFFC for offset 0x7FFFFF and -0x02000000 for offset 0x800000. A backward target below zero wraps modulo 2^32.
- R6: On an advancing edge with a taken branch and `br_link` = 1, `lr_o` becomes the old `pc_o + 4`.
- R7: A taken branch with `br_link` = 0 leaves `lr_o` unchanged.
- R8: When `br_valid` = 1 and `cond_pass` = 0, the branch has no effect. If `ret_req` = 0, `pc_o` advances by 4. `lr_o` is unchanged even when `br_link` = 1.
- R9: On an advancing edge with `ret_req` = 1 and no taken branch, `pc_o` becomes the current `lr_o`, and `lr_o` is unchanged.
- R10: When a taken branch and `ret_req` arrive on the same advancing edge, the branch wins and the return is ignored.
- R11: After `rst_n` rises, the first two rising clock edges still hold both registers in reset. The third edge is the first that can update them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adv_en | input | 1 | Advance enable: the registers update only on edges where this is 1 |
| br_valid | input | 1 | A branch is presented this cycle |
| br_link | input | 1 | The presented branch saves a return address |
| br_offset | input | 24 | Signed branch offset, counted in words |
| cond_pass | input | 1 | The condition of the branch holds |
| ret_req | input | 1 | Return: load the link register into the PC |
| pc_o | output | 32 | Current program counter |
| lr_o | output | 32 | Current link register |

## Verification
A wrong next-PC choice appears on `pc_o` one edge after the advancing cycle that caused it. Sequential steps, jump targets, link saves and returns are therefore each checked against a model on the edge right after stimulus. A corrupted link register can stay hidden until a return or an unexpected write exposes it. For this reason `lr_o` is compared on every edge, not only when a return happens. The reset-release delay shows on the very first advancing edges, so the counts of edges on which the PC stays at zero are checked directly.

// File: rtl/blu_pkg.sv
package blu_pkg;

  // Source of the next program counter value
  typedef enum logic [1:0] {
    NXT_HOLD = 2'd0,
    NXT_SEQ  = 2'd1,
    NXT_JUMP = 2'd2,
    NXT_RET  = 2'd3
  } nxt_src_e;

  localparam int unsigned INSN_BYTES = 4;

endpackage

// File: rtl/blu_rst_sync.sv
module blu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/blu_target_calc.sv
module blu_target_calc #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned OFF_W    = 24,
  parameter int unsigned ALIGN_SH = 2
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  seq_addr
);
  import blu_pkg::*;

  localparam int unsigned EXT_W = XLEN - OFF_W - ALIGN_SH;

  logic [XLEN-1:0] byte_off;

  generate
    if (ALIGN_SH > 0) begin : g_shift
      assign byte_off = {{EXT_W{offset[OFF_W-1]}}, offset, {ALIGN_SH{1'b0}}};
    end else begin : g_noshift
      assign byte_off = {{EXT_W{offset[OFF_W-1]}}, offset};
    end
  endgenerate

  always_comb begin
    target   = pc + byte_off;
    seq_addr = pc + XLEN'(INSN_BYTES);
  end

endmodule

// File: rtl/blu_next_sel.sv
module blu_next_sel #(
  parameter int unsigned XLEN = 32
) (
  input  logic                 adv_en,
  input  logic                 br_valid,
  input  logic                 br_link,
  input  logic                 cond_pass,
  input  logic                 ret_req,
  input  logic [XLEN-1:0]      target,
  input  logic [XLEN-1:0]      seq_addr,
  input  logic [XLEN-1:0]      lr_q,
  output blu_pkg::nxt_src_e    src,
  output logic                 pc_we,
  output logic [XLEN-1:0]      pc_d,
  output logic                 lr_we,
  output logic [XLEN-1:0]      lr_d
);
  import blu_pkg::*;

  logic taken;

  always_comb begin
    taken = br_valid & cond_pass;
    if (!adv_en) begin
      src = NXT_HOLD;
    end else if (taken) begin
      src = NXT_JUMP;
    end else if (ret_req) begin
      src = NXT_RET;
    end else begin
      src = NXT_SEQ;
    end
  end

  always_comb begin
    pc_we = (src != NXT_HOLD);
    unique case (src)
      NXT_JUMP: pc_d = target;
      NXT_RET:  pc_d = lr_q;
      NXT_SEQ:  pc_d = seq_addr;
      default:  pc_d = seq_addr;
    endcase
    lr_we = (src == NXT_JUMP) & br_link;
    lr_d  = seq_addr;
  end

endmodule

// File: rtl/blu_flow_regs.sv
module blu_flow_regs #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_we,
  input  logic [XLEN-1:0] pc_d,
  input  logic            lr_we,
  input  logic [XLEN-1:0] lr_d,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] lr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_we) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q <= '0;
    end else if (lr_we) begin
      lr_q <= lr_d;
    end
  end

endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit #(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned OFF_W       = 24,
  parameter int unsigned ALIGN_SH    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic             br_valid,
  input  logic             br_link,
  input  logic [OFF_W-1:0] br_offset,
  input  logic             cond_pass,
  input  logic             ret_req,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  lr_o
);
  import blu_pkg::*;

  logic            rst_int_n;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] lr_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] lr_d;
  logic            pc_we;
  logic            lr_we;
  nxt_src_e        src;

  blu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  blu_target_calc #(.XLEN(XLEN), .OFF_W(OFF_W), .ALIGN_SH(ALIGN_SH)) u_target (
    .pc       (pc_q),
    .offset   (br_offset),
    .target   (target),
    .seq_addr (seq_addr)
  );

  blu_next_sel #(.XLEN(XLEN)) u_next_sel (
    .adv_en    (adv_en),
    .br_valid  (br_valid),
    .br_link   (br_link),
    .cond_pass (cond_pass),
    .ret_req   (ret_req),
    .target    (target),
    .seq_addr  (seq_addr),
    .lr_q      (lr_q),
    .src       (src),
    .pc_we     (pc_we),
    .pc_d      (pc_d),
    .lr_we     (lr_we),
    .lr_d      (lr_d)
  );

  blu_flow_regs #(.XLEN(XLEN)) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pc_we (pc_we),
    .pc_d  (pc_d),
    .lr_we (lr_we),
    .lr_d  (lr_d),
    .pc_q  (pc_q),
    .lr_q  (lr_q)
  );

  assign pc_o = pc_q;
  assign lr_o = lr_q;

endmodule

// File: rtl/branch_link_unit_chk.sv
module branch_link_unit_chk #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned OFF_W    = 24,
  parameter int unsigned ALIGN_SH = 2
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             adv_en,
  input logic             br_valid,
  input logic             br_link,
  input logic [OFF_W-1:0] br_offset,
  input logic             cond_pass,
  input logic             ret_req,
  input logic [XLEN-1:0]  pc_o,
  input logic [XLEN-1:0]  lr_o
);

  localparam int unsigned EXT_W = XLEN - OFF_W - ALIGN_SH;

  logic taken;
  assign taken = br_valid & cond_pass;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_int_n |=> (pc_o == '0) && (lr_o == '0));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !adv_en |=> $stable(pc_o) && $stable(lr_o));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    adv_en && !taken && !ret_req |=> pc_o == $past(pc_o) + XLEN'(4));

  // R4
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    adv_en && taken |=> pc_o == $past(pc_o)
      + {{EXT_W{$past(br_offset[OFF_W-1])}}, $past(br_offset), {ALIGN_SH{1'b0}}});

  // R6
  link_save_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    adv_en && taken && br_link |=> lr_o == $past(pc_o) + XLEN'(4));

  // R7
  nolink_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    adv_en && taken && !br_link |=> $stable(lr_o));

  // R8
  failed_cond_keep_lr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    adv_en && !taken |=> $stable(lr_o));

  // R9
  return_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    adv_en && ret_req && !taken |=> pc_o == $past(lr_o));

endmodule

bind branch_link_unit branch_link_unit_chk #(
  .XLEN(XLEN), .OFF_W(OFF_W), .ALIGN_SH(ALIGN_SH)
) chk_i (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .adv_en    (adv_en),
  .br_valid  (br_valid),
  .br_link   (br_link),
  .br_offset (br_offset),
  .cond_pass (cond_pass),
  .ret_req   (ret_req),
  .pc_o      (pc_o),
  .lr_o      (lr_o)
);

// File: tb/branch_link_unit_tb_top.sv
module branch_link_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        adv_en;
  logic        br_valid;
  logic        br_link;
  logic [23:0] br_offset;
  logic        cond_pass;
  logic        ret_req;
  logic [31:0] pc_o;
  logic [31:0] lr_o;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  logic        finished = 1'b0;

  logic [31:0] m_pc;
  logic [31:0] m_lr;

  branch_link_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_en    (adv_en),
    .br_valid  (br_valid),
    .br_link   (br_link),
    .br_offset (br_offset),
    .cond_pass (cond_pass),
    .ret_req   (ret_req),
    .pc_o      (pc_o),
    .lr_o      (lr_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] f_target(input logic [31:0] pc, input logic [23:0] off);
    logic [31:0] ext;
    ext = {{6{off[23]}}, off, 2'b00};
    return pc + ext;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // One advancing cycle: drive at the falling edge, update the model at the
  // rising edge, compare shortly after it.
  task automatic step(input logic a, input logic v, input logic l, input logic c,
                      input logic r, input logic [23:0] off, input string tag);
    @(negedge clk);
    adv_en = a; br_valid = v; br_link = l; cond_pass = c; ret_req = r; br_offset = off;
    @(posedge clk);
    if (a) begin
      if (v && c) begin
        if (l) m_lr = m_pc + 32'd4;
        m_pc = f_target(m_pc, off);
      end else if (r) begin
        m_pc = m_lr;
      end else begin
        m_pc = m_pc + 32'd4;
      end
    end
    #1;
    check({tag, " pc"}, pc_o, m_pc);
    check({tag, " lr"}, lr_o, m_lr);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h0BAD_5EED);
    rst_n = 1'b1; adv_en = 1'b1; br_valid = 1'b0; br_link = 1'b0;
    cond_pass = 1'b0; ret_req = 1'b0; br_offset = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 pc", pc_o, 32'd0);
    check("R1 lr", lr_o, 32'd0);

    // R11: release with advance requested; two edges stay in reset
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1 check("R11 edge1 pc", pc_o, 32'd0);
    @(posedge clk); #1 check("R11 edge2 pc", pc_o, 32'd0);
    @(posedge clk); #1 check("R11 edge3 pc", pc_o, 32'd4);
    m_pc = 32'd4; m_lr = 32'd0;

    step(1, 0, 0, 0, 0, 24'h0, "R3 seq");
    step(1, 1, 1, 1, 0, 24'h000010, "R6 fwd link");
    step(1, 1, 0, 1, 0, 24'hFFFFF0, "R7 back nolink");
    step(0, 1, 1, 1, 1, 24'h000100, "R2 idle");
    step(1, 1, 1, 0, 0, 24'h000200, "R8 cond fail");
    step(1, 0, 0, 0, 1, 24'h0, "R9 return");
    step(1, 1, 0, 1, 1, 24'h000004, "R10 priority");
    step(1, 1, 0, 1, 0, 24'h7FFFFF, "R5 max fwd");
    step(1, 1, 0, 1, 0, 24'h800000, "R5 max back");
    // walk down to a small PC, then jump below zero
    step(1, 0, 0, 0, 1, 24'h0, "R9 return2");
    step(1, 1, 0, 1, 0, 24'hFFFFFC, "R5 wrap back");
    step(1, 0, 0, 0, 0, 24'h0, "R3 seq");
    step(1, 1, 1, 1, 1, 24'hFFFFFF, "R10 link prio");
    step(0, 0, 0, 0, 1, 24'h0, "R2 idle ret");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom();
      step(rv[0] | rv[1], rv[2], rv[3], rv[4] | rv[5], rv[6] & rv[7],
           {rv[8] ? 24'h0 : {rv[31], 23'h0}} ^ 24'($urandom()), "R4 random");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule